// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches a set of already sampled input pins, organised in banks of 32, and raises a flag for each pin whose configured trigger condition is met. Every bank has five word registers: an enable mask, three trigger-type bit planes and a sticky status word. Software sets a pin's mode by writing one bit in each of the three planes. One plane chooses edge or level. One chooses the polarity. The third turns on detection of both edges. Flags are acknowledged by writing ones to the status word.

The flags of every bank, each masked by its enable bit, are combined into one interrupt output. Reads are combinational from a separate read address, and writes take effect at the clock edge. After reset, every pin is disabled and set to single falling-edge detection.

Top module: `pin_irq_detect`

## Requirements
- R1: Synchronous reset (rst high) clears all enable, type and status bits and holds irq low. The mode with all type bits 0 is single falling edge.
- R2: Bank b's registers sit at byte address b*0x20 plus a word offset. Addresses are decoded from bits [4:2] and bits above them. The offsets are: enable +0x00, type0 +0x04, type1 +0x08, type2 +0x0C, status +0x10. The enable and type words read back as written. Offsets 0x14 to 0x1C and banks beyond the last read 0 and ignore writes.
- R3: A pin with type1=0, type2=0 and type0=0 sets its status bit when its sampled value goes from 1 to 0. The bit is set at the clock edge where the new value is sampled. A 0 to 1 change does not set it.
- R4: A pin with type1=0, type2=0 and type0=1 sets its status bit on a 0 to 1 change only.
- R5: A pin with type1=0 and type2=1 sets its status bit on any change of value, whatever type0 holds.
- R6: A pin with type1=1 sets its status bit on every clock where its value equals type0 (1 = high level, 0 = low level). If the bit is cleared while the level persists, it is set again.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R8: A status bit is set only while its enable bit is 1. A trigger on a disabled pin leaves the status bit as it was.
- R9: If a trigger and a clearing write hit the same status bit at the same clock edge, the bit ends up set.
- R10: irq is high exactly when some bank has a status bit set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NB*32 | Sampled pin values, bank b in bits [b*32+31:b*32] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Combined interrupt |

## Verification
A pin trigger and a software write to that pin's status word can land on the same clock edge. The bench sets this up on purpose in two ways. In the first, it writes a clear at the same edge where a pin rises in rising-edge mode. In the second, it writes a clear while a high-level pin keeps its level. It then reads the status word right after that edge and expects the bit to still be set. Random traffic writes clears at random times while the pins toggle at random, so such collisions also occur often. Every cycle is compared against a bench model.

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NB     = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NB*32-1:0]  pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int W  = 32;
  localparam int N  = NB * W;
  localparam int BW = ADDR_W - 5;

  logic [N-1:0] en_q, t0_q, t1_q, t2_q, st_q, prev_q;
  logic [N-1:0] rise, fall, edge_ev, lvl_ev, hit, clr;

  wire [BW-1:0] wr_bank = wr_addr[ADDR_W-1:5];
  wire [2:0]    wr_idx  = wr_addr[4:2];
  wire [BW-1:0] rd_bank = rd_addr[ADDR_W-1:5];
  wire [2:0]    rd_idx  = rd_addr[4:2];

  assign rise    = pin_in & ~prev_q;
  assign fall    = ~pin_in & prev_q;
  assign edge_ev = (t2_q & (rise | fall)) | (~t2_q & ((t0_q & rise) | (~t0_q & fall)));
  assign lvl_ev  = ~(pin_in ^ t0_q);
  assign hit     = en_q & ((t1_q & lvl_ev) | (~t1_q & edge_ev));

  generate
    for (genvar b = 0; b < NB; b++) begin : g_clr
      assign clr[b*W +: W] = (wr_en && wr_bank == BW'(b) && wr_idx == 3'd4) ? wr_data : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      t0_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      st_q   <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_in;
      st_q   <= (st_q & ~clr) | hit;
      for (int b = 0; b < NB; b++) begin
        if (wr_en && wr_bank == BW'(b)) begin
          case (wr_idx)
            3'd0: en_q[b*W +: W] <= wr_data;
            3'd1: t0_q[b*W +: W] <= wr_data;
            3'd2: t1_q[b*W +: W] <= wr_data;
            3'd3: t2_q[b*W +: W] <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_bank == BW'(b)) begin
        case (rd_idx)
          3'd0: rd_data = en_q[b*W +: W];
          3'd1: rd_data = t0_q[b*W +: W];
          3'd2: rd_data = t1_q[b*W +: W];
          3'd3: rd_data = t2_q[b*W +: W];
          3'd4: rd_data = st_q[b*W +: W];
          default: rd_data = '0;
        endcase
      end
    end
  end

  assign irq = |(st_q & en_q);
endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         irq,
  input logic [N-1:0] en_q,
  input logic [N-1:0] st_q,
  input logic [N-1:0] hit
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st_q == '0 && en_q == '0 && !irq));

  assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  assert_event_lands_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit) & ~st_q) == '0));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st_q != '0));
endmodule

bind pin_irq_detect pin_irq_detect_chk #(.N(N)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .irq  (irq),
  .en_q (en_q),
  .st_q (st_q),
  .hit  (hit)
);

// File: tb/pin_irq_detect_test.sv
`timescale 1ns/100ps
module pin_irq_detect_test;
  localparam int NB = 2;
  localparam int AW = 8;
  localparam int N  = NB * 32;

  logic          clk = 0;
  logic          rst = 1;
  logic [N-1:0]  pin_in = '0;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit [N-1:0] m_en, m_t0, m_t1, m_t2, m_st, m_prev;

  pin_irq_detect #(.NB(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic bit trig(bit t1, bit t2, bit t0, bit cur, bit prv);
    if (t1) return t0 ? cur : !cur;
    if (t2) return cur != prv;
    if (t0) return cur && !prv;
    return !cur && prv;
  endfunction

  function automatic bit [31:0] exp_rd(bit [AW-1:0] a);
    int b = int'(a[AW-1:5]);
    if (b >= NB) return '0;
    case (a[4:2])
      3'd0: return m_en[b*32 +: 32];
      3'd1: return m_t0[b*32 +: 32];
      3'd2: return m_t1[b*32 +: 32];
      3'd3: return m_t2[b*32 +: 32];
      3'd4: return m_st[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  task automatic step(bit [N-1:0] pins, bit we, bit [AW-1:0] a, bit [31:0] d);
    bit [N-1:0] nst;
    int b;
    @(negedge clk);
    pin_in = pins; wr_en = we; wr_addr = a; wr_data = d;
    nst = m_st;
    b = int'(a[AW-1:5]);
    for (int i = 0; i < N; i++) begin
      bit c = we && b == i / 32 && a[4:2] == 3'd4 && d[i % 32];
      bit e = m_en[i] && trig(m_t1[i], m_t2[i], m_t0[i], pins[i], m_prev[i]);
      nst[i] = e ? 1'b1 : (c ? 1'b0 : m_st[i]);
    end
    @(posedge clk);
    m_st = nst;
    m_prev = pins;
    if (we && b < NB) begin
      case (a[4:2])
        3'd0: m_en[b*32 +: 32] = d;
        3'd1: m_t0[b*32 +: 32] = d;
        3'd2: m_t1[b*32 +: 32] = d;
        3'd3: m_t2[b*32 +: 32] = d;
        default: ;
      endcase
    end
    #1;
    wr_en = 0;
  endtask

  task automatic chk(string tag, bit [AW-1:0] a);
    rd_addr = a;
    #0.1;
    checks++;
    if (rd_data !== exp_rd(a)) begin
      errors++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, rd_data, exp_rd(a));
    end
  endtask

  task automatic chk_irq(string tag);
    bit e = |(m_st & m_en);
    #0.1;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq got=%b exp=%b", tag, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_en = '0; m_t0 = '0; m_t1 = '0; m_t2 = '0; m_st = '0; m_prev = '0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      chk("R1", AW'(a * 4));
      chk("R1", AW'(32 + a * 4));
    end
    chk_irq("R1");
    // R2 register map read back
    step('0, 1, 8'h04, 32'hA5A5_0000); chk("R2", 8'h04);
    step('0, 1, 8'h04, 32'h0);         chk("R2", 8'h04);
    step('0, 1, 8'h2C, 32'h1234_5678); chk("R2", 8'h2C);
    step('0, 1, 8'h2C, 32'h0);         chk("R2", 8'h2C);
    step('0, 1, 8'h14, 32'hFFFF_FFFF); chk("R2", 8'h14); chk("R2", 8'h00);
    step('0, 1, 8'h00, 32'hFFFF_FFFF); chk("R2", 8'h00);
    // R3 falling edge default
    step(64'hF, 0, 0, 0); chk("R3", 8'h10);
    step(64'h0, 0, 0, 0); chk("R3", 8'h10); chk_irq("R10");
    // R7 write-1-clear
    step(64'h0, 1, 8'h10, 32'h3); chk("R7", 8'h10);
    step(64'h0, 1, 8'h10, 32'h0); chk("R7", 8'h10);
    step(64'h0, 1, 8'h10, 32'hC); chk("R7", 8'h10); chk_irq("R10");
    // R4 rising and R5 both edges
    step(64'h0, 1, 8'h04, 32'h3);
    step(64'h0, 1, 8'h0C, 32'h2);
    step(64'h3, 0, 0, 0); chk("R4", 8'h10);
    step(64'h3, 1, 8'h10, 32'hFFFF_FFFF); chk("R4", 8'h10);
    step(64'h0, 0, 0, 0); chk("R5", 8'h10);
    step(64'h0, 1, 8'h10, 32'hFFFF_FFFF);
    // R9 rising event with simultaneous clear
    step(64'h1, 1, 8'h10, 32'h1); chk("R9", 8'h10);
    step(64'h1, 1, 8'h10, 32'hFFFF_FFFF); chk("R9", 8'h10);
    // R6 level modes
    step(64'h1, 1, 8'h04, 32'h0000_0011);
    step(64'h1, 1, 8'h08, 32'h0000_0030);
    step(64'h31, 1, 8'h10, 32'hFFFF_FFFF); chk("R6", 8'h10);
    step(64'h31, 1, 8'h10, 32'h10); chk("R6", 8'h10);
    step(64'h01, 0, 0, 0); chk("R6", 8'h10);
    step(64'h01, 1, 8'h10, 32'hFFFF_FFFF); chk("R6", 8'h10);
    step(64'h21, 1, 8'h08, 32'h0);
    step(64'h21, 1, 8'h10, 32'hFFFF_FFFF); chk("R6", 8'h10);
    // R8 disabled pins
    step(64'h0, 1, 8'h00, 32'h0);
    step(64'hFF, 0, 0, 0);
    step(64'h00, 0, 0, 0); chk("R8", 8'h10); chk_irq("R8");
    // R10 second bank and enable masking
    step(64'h0, 1, 8'h20, 32'h8000_0000);
    step(64'h8000_0000_0000_0000, 0, 0, 0);
    step(64'h0, 0, 0, 0); chk("R10", 8'h30); chk_irq("R10");
    step(64'h0, 1, 8'h20, 32'h0); chk("R10", 8'h30); chk_irq("R10");
    step(64'h0, 1, 8'h30, 32'hFFFF_FFFF); chk_irq("R10");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      bit [N-1:0] p = {$urandom, $urandom};
      bit [AW-1:0] a = AW'({$urandom_range(0, 2), 3'($urandom_range(0, 5)), 2'b00});
      bit [31:0] d = $urandom;
      if ($urandom_range(0, 3) != 0) p = m_prev ^ (N'(1) << $urandom_range(0, N - 1));
      step(p, $urandom_range(0, 1) == 1, a, d);
      chk("R2", AW'({$urandom_range(0, 2), 3'($urandom_range(0, 5)), 2'b00}));
      chk("R7", 8'h10);
      chk("R9", 8'h30);
      chk_irq("R10");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule